// File: doc/BRIEF.md
# Masked Set-Before-First Mask Unit

This block takes a bit-vector mask and returns, for every element below the lowest set source bit, a 1, and for that bit and every element above it, a 0. Each bit is one element. Element 0 is the least significant bit, and the search runs upward from there. When the source holds no qualifying set bit, every active element of the result is 1.

Per-element predication is optional. When the predication enable is high, only elements whose predicate bit is 1 are active. Two things follow from that. First, a set source bit at an inactive position does not end the run of ones. Second, inactive result elements take their value from the previous-destination input, so the output is fully defined. When the enable is low, every element is active and the predicate input is ignored.

The result and its valid strobe are registered, so a result appears one clock after its input valid.

Top module: `before_first_mask`

## Requirements
- R1: With predication disabled, every result bit at an index below the lowest set source bit is 1 (source 8'b10010100 gives 8'b00000011).
- R2: The result bit at the lowest qualifying set source bit is 0, and so is every active bit above it (source 8'b10010101 gives 8'b00000000 when unpredicated).
- R3: When no active element has its source bit set, every active result bit is 1 (an all-zero source gives all ones when unpredicated).
- R4: With predication enabled, a source bit counts only where the predicate bit is 1. With predicate 8'b11000011 and source 8'b10010100, bits 6, 1 and 0 become 1 and bit 7 becomes 0.
- R5: With predication disabled, the predicate input has no effect and all elements are active.
- R6: With predication enabled, each result bit whose predicate bit is 0 equals the matching bit of the previous-destination input.
- R7: out_valid is high exactly one clock after in_valid is high, and out_mask in that cycle is the result for the inputs presented with in_valid.
- R8: While in_valid is low, out_mask holds its last value.
- R9: A synchronous active-high reset clears out_valid and out_mask to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are valid this cycle |
| src_mask | input | WIDTH | Source mask searched for its first set bit |
| pred_mask | input | WIDTH | Predicate, 1 marks an active element |
| pred_en | input | 1 | 1 enables predication, 0 makes all elements active |
| prev_dst | input | WIDTH | Value given to inactive result elements |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_mask | output | WIDTH | Registered result vector |

## Verification
The bench builds two copies of the block side by side, one at WIDTH 8 and one at the default WIDTH 64, and drives both from the same stimulus. The 8-bit copy makes the worked bit patterns exact and checks the top-bit boundary directly. The 64-bit copy lets random vectors place the first set bit far from both ends, so the carry chain must cross many elements. In both copies, predicates mix set source bits at inactive positions with previous-destination values.

// File: rtl/before_first_mask.sv
module before_first_mask #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] src_mask,
  input  logic [WIDTH-1:0] pred_mask,
  input  logic             pred_en,
  input  logic [WIDTH-1:0] prev_dst,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_mask
);

  logic [WIDTH-1:0] active;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] seen;
  logic [WIDTH-1:0] result;

  assign active = pred_en ? pred_mask : {WIDTH{1'b1}};
  assign hit    = src_mask & active;
  // x | -x sets every bit from the lowest set bit of x upward
  assign seen   = hit | (~hit + {{(WIDTH-1){1'b0}}, 1'b1});
  assign result = (active & ~seen) | (~active & prev_dst);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= result;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_mask)); // R8
  AST_SET_SRC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pred_en) |=> ((out_mask & $past(src_mask)) == '0)); // R2
  AST_INACTIVE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred_en) |=>
      (((out_mask ^ $past(prev_dst)) & ~$past(pred_mask)) == '0)); // R6
  AST_EMPTY_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred_en && ((src_mask & pred_mask) == '0)) |=>
      ((out_mask & $past(pred_mask)) == $past(pred_mask))); // R3

endmodule

// File: tb/test_before_first_mask.sv
`timescale 1ns/1ps
module test_before_first_mask;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0, pred = '0, prev = '0;
  logic        pen = 1'b0;
  logic        v64, v8;
  logic [63:0] m64;
  logic [7:0]  m8;
  int          n_vec = 0, n_bad = 0;
  bit          checking = 0, done = 0;
  string       tag = "R9";

  always #4 clk = ~clk;

  before_first_mask #(.WIDTH(64)) i_before_first_mask (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_mask(src),
    .pred_mask(pred), .pred_en(pen), .prev_dst(prev),
    .out_valid(v64), .out_mask(m64));

  before_first_mask #(.WIDTH(8)) i_before_first_mask_w8 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_mask(src[7:0]),
    .pred_mask(pred[7:0]), .pred_en(pen), .prev_dst(prev[7:0]),
    .out_valid(v8), .out_mask(m8));

  function automatic logic [63:0] model(input logic [63:0] s, p, d,
                                        input logic en, input int w);
    logic [63:0] r = '0;
    bit found = 0;
    for (int i = 0; i < w; i++) begin
      bit act = !en || p[i];
      if (act && s[i]) found = 1;
      r[i] = act ? !found : d[i];
    end
    return r;
  endfunction

  logic        ev = 0;
  logic [63:0] e64 = '0, e8 = '0;
  string       etag = "R9";

  always @(posedge clk) begin
    etag <= tag;
    if (rst) begin
      ev <= 0; e64 <= '0; e8 <= '0;
    end else begin
      ev <= in_valid;
      if (in_valid) begin
        e64 <= model(src, pred, prev, pen, 64);
        e8  <= model(src, pred, prev, pen, 8);
      end
    end
  end

  always @(negedge clk) if (checking && !done) begin
    n_vec++;
    if (v64 !== ev || m64 !== e64) begin
      n_bad++;
      $display("FAIL %s w64: got v=%b m=%h expected v=%b m=%h", etag, v64, m64, ev, e64);
    end
    if (v8 !== ev || m8 !== e8[7:0]) begin
      n_bad++;
      $display("FAIL %s w8: got v=%b m=%h expected v=%b m=%h", etag, v8, m8, ev, e8[7:0]);
    end
  end

  task automatic drive(input string t, input logic v, input logic [63:0] s, p, d,
                       input logic en);
    @(negedge clk);
    tag = t; in_valid = v; src = s; pred = p; prev = d; pen = en;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    checking = 1;            // R9: outputs zero while in reset
    repeat (2) @(negedge clk);
    rst = 0;
    drive("R1", 1, 64'h94, '0, '0, 0);
    drive("R2", 1, 64'h95, '0, '0, 0);
    drive("R3", 1, 64'h0, '0, '0, 0);
    drive("R4", 1, 64'h94, 64'hC3, 64'h0, 1);
    drive("R4", 1, 64'h94, 64'hC3, 64'h3C, 1);
    drive("R5", 1, 64'h94, 64'h0, 64'hFF, 0);
    drive("R6", 1, 64'hFFFF, 64'h0, 64'hA5A5_0000_1234_5678, 1);
    drive("R2", 1, 64'h8000_0000_0000_0080, '0, '0, 0);
    drive("R3", 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1);
    drive("R8", 0, 64'h1, 64'h0, 64'h0, 0);
    drive("R8", 0, 64'h2, 64'h5, 64'hF, 1);
    drive("R7", 1, 64'h10, '0, '0, 0);
    drive("R7", 1, 64'h1, '0, '0, 0);
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] s = {$urandom, $urandom};
      if (k % 4 == 1) s = s & {$urandom, $urandom} & {$urandom, $urandom};
      if (k % 7 == 3) s = 64'h1 << ($urandom % 64);
      drive("R4", ($urandom % 5) != 0, s, {$urandom, $urandom},
            {$urandom, $urandom}, $urandom % 2);
    end
    drive("R9", 1, 64'h94, '0, '0, 0);
    @(negedge clk); rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule